// File: doc/BRIEF.md
# Packed Vector Arithmetic Right Shifter

This execution unit takes a 256-bit data operand and shifts every packed lane right arithmetically. All lanes use one shared count. A lane is either a 16-bit word or a 32-bit doubleword. The bits vacated at the top of each lane are filled with copies of that lane's original sign bit. The count comes from one of two places: the low 64 bits of a 128-bit count operand, or an 8-bit immediate that is zero-extended. In either case the count is clamped to the lane width minus one, so an oversized count leaves each lane as copies of its sign bit.

A mode input decides what happens to the upper 128 result bits. In mode 0 they are copied from the prior destination value. In mode 1 they are cleared. In modes 2 and 3 they are computed from the source lanes like the lower half.

The unit has one registered stage. A two-state controller sets the output valid flag. ST_IDLE means no fresh result, and ST_VALID means a result was captured on the previous edge. The transition GO_VALID is taken on any edge with valid_in high, from either state. The transition GO_IDLE is taken on any edge with valid_in low, or with reset.

Top module: `sra_vector_shifter`

## Requirements
- R1: When valid_in is high, every lane of result is the arithmetic right shift of the same source lane by the effective count. The vacated upper bits of the lane equal the lane's original most significant bit. Lanes sit at bit offsets lane_index*lane_width.
- R2: When imm_sel is 0, the effective count is count_op[63:0], read as an unsigned value. Bits count_op[127:64] have no effect on result.
- R3: When elem_dw is 0 (16-bit lanes), any effective count above 15 gives the same result as a count of 15. This includes counts with only bits above bit 31 set, such as 2^63.
- R4: When elem_dw is 1 (32-bit lanes), any effective count above 31 gives the same result as a count of 31.
- R5: When imm_sel is 1, the effective count is count_imm zero-extended to 64 bits, and count_op has no effect.
- R6: In mode 0, result[255:128] equals dst_old[255:128] as sampled with valid_in. The lower half is shifted as in R1.
- R7: In mode 1, result[255:128] is zero. The lower half is shifted as in R1.
- R8: In mode 2 and mode 3, all 256 result bits are shifted source lanes.
- R9: valid_out is high exactly one cycle after each cycle with valid_in high, and low otherwise. When valid_in is low, result holds its value. Synchronous reset clears valid_out and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands are present this cycle |
| src | input | 256 | Packed source lanes |
| count_op | input | 128 | Register count operand; only bits [63:0] are used |
| count_imm | input | 8 | Immediate count |
| imm_sel | input | 1 | 1 selects the immediate count |
| dst_old | input | 256 | Prior destination value |
| elem_dw | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| mode | input | 2 | 0 keep upper half, 1 clear upper half, 2 or 3 full width |
| valid_out | output | 1 | Result is valid |
| result | output | 256 | Registered shifted result |

## Verification
The controller state drives valid_out directly. A state stuck in ST_VALID or ST_IDLE therefore shows up one cycle later as a valid flag without a pending expected item, or as a missing item. A wrong clamp or count selection corrupts lane bits that the bench compares on the very next valid cycle. The corner counts 0, 15, 16, 31, 32 and 2^63, and garbage placed in count_op[127:64], make those errors visible. A wrong mode decode appears in the upper 128 bits of that same result. Loading result while valid_in is low breaks the hold check on the following idle cycle.

// File: rtl/sra_pkg.sv
package sra_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP_HI = 2'd0,
        MODE_ZERO_HI = 2'd1,
        MODE_FULL    = 2'd2,
        MODE_FULL_B  = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } state_e;
endpackage

// File: rtl/sra_count_clamp.sv
module sra_count_clamp #(
    parameter int CNT_W  = 128,
    parameter int USED_W = 64,
    parameter int IMM_W  = 8,
    parameter int LANE_W = 16,
    localparam int AMT_W = $clog2(LANE_W)
) (
    input  logic [CNT_W-1:0] count_op,
    input  logic [IMM_W-1:0] count_imm,
    input  logic             imm_sel,
    output logic [AMT_W-1:0] amt
);
    logic [USED_W-1:0] eff;
    localparam logic [USED_W-1:0] LIMIT = USED_W'(LANE_W - 1);

    always_comb begin
        if (imm_sel) begin
            eff = {{(USED_W-IMM_W){1'b0}}, count_imm};
        end else begin
            eff = count_op[USED_W-1:0];
        end
        if (eff > LIMIT) begin
            amt = LIMIT[AMT_W-1:0];
        end else begin
            amt = eff[AMT_W-1:0];
        end
    end
endmodule

// File: rtl/sra_lane_array.sv
module sra_lane_array #(
    parameter int DATA_W = 256,
    parameter int LANE_W = 16,
    localparam int AMT_W  = $clog2(LANE_W),
    localparam int LANES  = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LANE_W-1:0] lane_in;
        assign lane_in = din[g*LANE_W +: LANE_W];
        assign dout[g*LANE_W +: LANE_W] = lane_in >>> amt;
    end
endmodule

// File: rtl/sra_half_merge.sv
module sra_half_merge
    import sra_pkg::*;
#(
    parameter int DATA_W = 256,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        merged[HALF_W-1:0] = shifted[HALF_W-1:0];
        unique case (mode_e'(mode))
            MODE_KEEP_HI: merged[DATA_W-1:HALF_W] = dst_old[DATA_W-1:HALF_W];
            MODE_ZERO_HI: merged[DATA_W-1:HALF_W] = '0;
            MODE_FULL,
            MODE_FULL_B:  merged[DATA_W-1:HALF_W] = shifted[DATA_W-1:HALF_W];
            default:      merged[DATA_W-1:HALF_W] = shifted[DATA_W-1:HALF_W];
        endcase
    end
endmodule

// File: rtl/sra_vector_shifter.sv
module sra_vector_shifter
    import sra_pkg::*;
#(
    parameter int DATA_W  = 256,
    parameter int CNT_W   = 128,
    parameter int USED_W  = 64,
    parameter int IMM_W   = 8,
    parameter int WORD_W  = 16,
    parameter int DWORD_W = 32,
    localparam int WAMT_W = $clog2(WORD_W),
    localparam int DAMT_W = $clog2(DWORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  count_op,
    input  logic [IMM_W-1:0]  count_imm,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] dst_old,
    input  logic              elem_dw,
    input  logic [1:0]        mode,
    output logic              valid_out,
    output logic [DATA_W-1:0] result
);
    logic [WAMT_W-1:0] amt_w;
    logic [DAMT_W-1:0] amt_d;
    logic [DATA_W-1:0] sh_w, sh_d, sh_sel, merged;
    state_e            state_q, state_d;

    sra_count_clamp #(.CNT_W(CNT_W), .USED_W(USED_W), .IMM_W(IMM_W), .LANE_W(WORD_W)) u_clamp_w (
        .count_op(count_op), .count_imm(count_imm), .imm_sel(imm_sel), .amt(amt_w));
    sra_count_clamp #(.CNT_W(CNT_W), .USED_W(USED_W), .IMM_W(IMM_W), .LANE_W(DWORD_W)) u_clamp_d (
        .count_op(count_op), .count_imm(count_imm), .imm_sel(imm_sel), .amt(amt_d));

    sra_lane_array #(.DATA_W(DATA_W), .LANE_W(WORD_W))  u_lanes_w (.din(src), .amt(amt_w), .dout(sh_w));
    sra_lane_array #(.DATA_W(DATA_W), .LANE_W(DWORD_W)) u_lanes_d (.din(src), .amt(amt_d), .dout(sh_d));

    assign sh_sel = elem_dw ? sh_d : sh_w;

    sra_half_merge #(.DATA_W(DATA_W)) u_merge (
        .shifted(sh_sel), .dst_old(dst_old), .mode(mode), .merged(merged));

    // Next-state: GO_VALID on valid_in, GO_IDLE otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = valid_in ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = valid_in ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captures only on GO_VALID
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (state_d == ST_VALID) begin
            result <= merged;
        end
    end

    assign valid_out = (state_q == ST_VALID);
endmodule

// File: rtl/sra_vector_shifter_chk.sv
module sra_vector_shifter_chk #(
    parameter int DATA_W = 256,
    parameter int CNT_W  = 128,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [DATA_W-1:0] src,
    input logic [CNT_W-1:0]  count_op,
    input logic [IMM_W-1:0]  count_imm,
    input logic              imm_sel,
    input logic [DATA_W-1:0] dst_old,
    input logic              elem_dw,
    input logic [1:0]        mode,
    input logic              valid_out,
    input logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;
    logic [63:0] eff;
    assign eff = imm_sel ? {{(64-IMM_W){1'b0}}, count_imm} : count_op[63:0];

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result));
    assert_keep_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && mode == 2'd0) |=> result[DATA_W-1:HALF_W] == $past(dst_old[DATA_W-1:HALF_W]));
    assert_zero_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && mode == 2'd1) |=> result[DATA_W-1:HALF_W] == '0);
    assert_zero_count_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_in && eff == 64'd0 && mode[1]) |=> result == $past(src));
    assert_word_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !elem_dw && eff > 64'd15) |=> result[15:0] == {16{$past(src[15])}});
    assert_dword_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_in && elem_dw && eff > 64'd31) |=> result[31:0] == {32{$past(src[31])}});
endmodule

bind sra_vector_shifter sra_vector_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst(rst), .valid_in(valid_in), .src(src), .count_op(count_op),
    .count_imm(count_imm), .imm_sel(imm_sel), .dst_old(dst_old), .elem_dw(elem_dw),
    .mode(mode), .valid_out(valid_out), .result(result));

// File: tb/test_sra_vector_shifter.sv
module test_sra_vector_shifter;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [255:0] src = '0;
    logic [127:0] count_op = '0;
    logic [7:0]   count_imm = '0;
    logic         imm_sel = 1'b0;
    logic [255:0] dst_old = '0;
    logic         elem_dw = 1'b0;
    logic [1:0]   mode = 2'd2;
    logic         valid_out;
    logic [255:0] result;

    int checks = 0;
    int fails = 0;
    logic [255:0] q_exp[$];
    string        q_tag[$];
    logic [255:0] last_res = '0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    sra_vector_shifter i_sra_vector_shifter (
        .clk(clk), .rst(rst), .valid_in(valid_in), .src(src), .count_op(count_op),
        .count_imm(count_imm), .imm_sel(imm_sel), .dst_old(dst_old), .elem_dw(elem_dw),
        .mode(mode), .valid_out(valid_out), .result(result));

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] model(logic [255:0] s, logic [127:0] c, logic [7:0] im,
                                           logic isel, logic dw, logic [1:0] md, logic [255:0] d);
        logic [255:0] r;
        logic [63:0]  e;
        int lw, amt;
        e  = isel ? {56'd0, im} : c[63:0];
        lw = dw ? 32 : 16;
        if (e > 64'(lw - 1)) amt = lw - 1;
        else amt = int'(e[5:0]);
        for (int l = 0; l < 256 / lw; l++) begin
            for (int b = 0; b < lw; b++) begin
                if (b + amt < lw) r[l*lw + b] = s[l*lw + b + amt];
                else r[l*lw + b] = s[l*lw + lw - 1];
            end
        end
        if (md == 2'd0) r[255:128] = d[255:128];
        else if (md == 2'd1) r[255:128] = '0;
        return r;
    endfunction

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic [255:0] s, logic [127:0] c, logic [7:0] im,
                         logic isel, logic dw, logic [1:0] md);
        logic [255:0] d;
        d = rnd256();
        @(negedge clk);
        src = s; count_op = c; count_imm = im; imm_sel = isel;
        elem_dw = dw; mode = md; dst_old = d; valid_in = 1'b1;
        q_exp.push_back(model(s, c, im, isel, dw, md, d));
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_in = 1'b0;
            src = rnd256(); count_op = {rnd256()}[127:0];
            count_imm = 8'($urandom); dst_old = rnd256();
        end
    endtask

    // Monitor: pops the scoreboard on every valid result, checks hold otherwise
    always @(negedge clk) begin
        if (rst) begin
            last_res = '0;
        end else if (valid_out) begin
            if (q_exp.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=valid_out 1 expected=valid_out 0");
            end else begin
                check(q_tag.pop_front(), result, q_exp.pop_front());
            end
            last_res = result;
        end else if (!done) begin
            check("R9 hold", result, last_res);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] corners[6];
        corners = '{64'd0, 64'd15, 64'd16, 64'd31, 64'd32, 64'h8000_0000_0000_0000};
        repeat (3) @(negedge clk);
        check("R9 reset valid_out", {255'd0, valid_out}, '0);
        check("R9 reset result", result, '0);
        rst = 1'b0;
        idle(2);

        // R1 R3 R4 R8: corner counts in both lane sizes, full width
        for (int k = 0; k < 6; k++) begin
            drive("R3 word corner", rnd256(), {64'd0, corners[k]}, 8'd0, 1'b0, 1'b0, 2'd2);
            drive("R4 dword corner", rnd256(), {64'd0, corners[k]}, 8'd0, 1'b0, 1'b1, 2'd2);
        end
        drive("R1 negative lanes", {256{1'b1}} ^ {16{16'h00f0}}, 128'd4, 8'd0, 1'b0, 1'b0, 2'd2);
        drive("R1 alternating", {64{4'b1010}}, 128'd3, 8'd0, 1'b0, 1'b1, 2'd3);
        // R2: upper count bits ignored
        drive("R2 upper bits ignored", rnd256(), {64'hffff_ffff_ffff_ffff, 64'd5}, 8'd0, 1'b0, 1'b0, 2'd2);
        drive("R2 upper bits ignored", rnd256(), {64'h1234_0000_0000_0001, 64'd0}, 8'd0, 1'b0, 1'b1, 2'd2);
        // R5: immediate
        drive("R5 immediate", rnd256(), {64'hdead, 64'd0}, 8'd7, 1'b1, 1'b0, 2'd2);
        drive("R5 immediate large", rnd256(), 128'd1, 8'd200, 1'b1, 1'b1, 2'd2);
        drive("R5 immediate zero", rnd256(), 128'd9, 8'd0, 1'b1, 1'b0, 2'd3);
        idle(1);
        // R6 R7: modes
        drive("R6 keep upper", rnd256(), 128'd2, 8'd0, 1'b0, 1'b0, 2'd0);
        drive("R6 keep upper clamp", rnd256(), 128'd40, 8'd0, 1'b0, 1'b1, 2'd0);
        drive("R7 zero upper", rnd256(), 128'd9, 8'd0, 1'b0, 1'b0, 2'd1);
        drive("R7 zero upper imm", rnd256(), 128'd0, 8'd33, 1'b1, 1'b1, 2'd1);
        idle(3);
        // Random mix
        for (int k = 0; k < 40; k++) begin
            drive("R1 random", rnd256(), {rnd256()}[127:0] & {64'hffff_ffff_ffff_ffff, 64'h3f},
                  8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
            if (k % 7 == 0) idle(1);
        end
        idle(3);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL R9 actual=%0d pending expected=0 pending", q_exp.size());
        end
        // R9: reset clears a live result
        drive("R9 before reset", rnd256(), 128'd1, 8'd0, 1'b0, 1'b0, 2'd2);
        idle(1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run valid_out", {255'd0, valid_out}, '0);
        check("R9 reset mid-run result", result, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule